// File: doc/BRIEF.md
# Deep-Stop Entry and Wakeup Sequencer

This block sequences a small microcontroller into and out of its deepest low-power state. Software writes a control byte. Setting the top bit of that byte requests the stop state. The sequencer then drops the core and peripheral clock enables and applies the chosen pad policy: outputs either held or high-impedance, with the wakeup pad always high-impedance. It then waits for a wakeup condition on the wakeup pin, sampled either for a rising edge or for a high level.

Once released, it counts ticks of the selected oscillator for a warm-up period. The length of that period comes from a 2-bit code together with the destination mode. It then resumes either high-speed or low-speed run and clears the request bit. A release through the reset pin always lands in high-speed run.

When pad outputs are not held, the interrupt-capable port inputs read as zero while the core is halted. The block reports any falling edge that this gating creates, so the interrupt logic sees it. The oscillators, the processor and the pad cells sit outside this block. It sees them only as tick strobes, pins and enable outputs.

Top module: `deepstop_seq`

## Requirements
- R1: After synchronous reset the control byte reads 0x00 and `mode_o` is 00. `mode_o` codes are 00 high-speed run, 01 low-speed run, 10 stopped, 11 warm-up. Both clock enables are 1, and all pad-policy outputs and `int_gated`/`int_fall` are 0.
- R2: The control byte fields are: bit7 stop request, bit6 release method (1 level, 0 edge), bit5 return mode (1 low-speed), bit4 pad outputs held (1) or high-Z (0), bits3:2 warm-up code. Bits1:0 always read 0. Writes take effect only while `mode_o` is a run mode and are ignored while stopped or warming up.
- R3: While running, a set stop request moves `mode_o` to 10 on the next clock and clears both clock enables. The one exception is the case covered by R4.
- R4: In level mode, if the synchronised wakeup level is already high when the request is seen, the stop state is not entered. The mode stays unchanged and bit7 clears on the next clock.
- R5: The wakeup pin passes through a two-flop synchroniser. In edge mode only a synchronised low-to-high transition seen while stopped releases the stop state; a level that is already high does not. In level mode a high synchronised level releases it. Release always goes to warm-up (11), never straight to run.
- R6: When the destination is high-speed run, warm-up lasts for codes 00/01/10/11 of 3·2^16, 2^16, 3·2^14 and 2^14 `hi_tick` strobes. Each count is shifted right by HI_SHIFT, with a minimum of 1.
- R7: When the destination is low-speed run, warm-up lasts for codes 00/01/10/11 of 3·2^13, 2^13, 3·2^6 and 2^6 `lo_tick` strobes. Each count is shifted right by LO_SHIFT, with a minimum of 1.
- R8: A high `pin_reset` while stopped starts warm-up towards high-speed run, using the R6 count, whatever bit5 holds. While running, `pin_reset` has no effect.
- R9: In the clock on which the last warm-up strobe arrives, `mode_o` becomes the destination run mode, both clock enables return to 1 and bit7 clears.
- R10: While stopped or warming up, `wake_pad_hiz` is 1, and `pad_hold` equals bit4 while `pad_hiz` is its inverse. While running, all three are 0.
- R11: `int_gated` is the registered `int_pin`, forced to 0 while stopped or warming up with bit4 at 0. `int_fall` pulses for one clock in the clock where a bit of `int_gated` goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte read value |
| wake_pin | input | 1 | Asynchronous wakeup pin |
| pin_reset | input | 1 | Reset-pin release request |
| hi_tick | input | 1 | One-clock strobe per high-speed oscillator cycle |
| lo_tick | input | 1 | One-clock strobe per low-speed oscillator cycle |
| int_pin | input | INT_W | Interrupt-capable port inputs |
| mode_o | output | 2 | Operating mode code |
| core_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pad_hold | output | 1 | Port outputs held at their last value |
| pad_hiz | output | 1 | Port outputs high-impedance |
| wake_pad_hiz | output | 1 | Wakeup pad high-impedance |
| int_gated | output | INT_W | Port inputs as seen by interrupt logic |
| int_fall | output | INT_W | Falling-edge event on gated inputs |

## Verification
The level-mode entry decision can coincide with the wakeup pin rising: the stop request and a freshly synchronised wakeup level can land in the same clock. The bench sweeps the pin's rise across six offsets around the control write. Depending on the offset, the sequencer either aborts the request or stops and is released at once. A behavioural reference model, compared every clock, judges the mode, the clearing of the request bit and whether the gated-input falling edge is reported. A second overlap, the forced-zero falling edge arriving on the same clock as stop entry, is checked in the same comparison.

// File: rtl/deepstop_pkg.sv
package deepstop_pkg;

  localparam int CTRL_W = 6;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 18;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WARM = 2'd2
  } ds_state_e;

  localparam logic [1:0] MODE_FAST = 2'b00;
  localparam logic [1:0] MODE_SLOW = 2'b01;
  localparam logic [1:0] MODE_STOP = 2'b10;
  localparam logic [1:0] MODE_WARM = 2'b11;

  typedef struct packed {
    logic       start;
    logic       lvl_rel;
    logic       ret_slow;
    logic       hold_out;
    logic [1:0] wsel;
  } ds_ctrl_t;

  function automatic logic [31:0] warm_limit(input logic slow, input logic [1:0] sel,
                                             input int hs, input int ls);
    logic [31:0] base;
    int          sh;
    if (!slow) begin
      sh = hs;
      case (sel)
        2'd0:    base = 32'd3 << 16;
        2'd1:    base = 32'd1 << 16;
        2'd2:    base = 32'd3 << 14;
        default: base = 32'd1 << 14;
      endcase
    end else begin
      sh = ls;
      case (sel)
        2'd0:    base = 32'd3 << 13;
        2'd1:    base = 32'd1 << 13;
        2'd2:    base = 32'd3 << 6;
        default: base = 32'd1 << 6;
      endcase
    end
    base = base >> sh;
    if (base == 32'd0) base = 32'd1;
    return base;
  endfunction

endpackage

// File: rtl/ds_ctrl_reg.sv
module ds_ctrl_reg
  import deepstop_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_allow,
  input  logic              clr_start,
  output ds_ctrl_t          ctrl,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int PAD_W = BYTE_W - CTRL_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en && wr_allow) begin
      ctrl <= ds_ctrl_t'(wr_data[BYTE_W-1:PAD_W]);
    end else if (clr_start) begin
      ctrl.start <= 1'b0;
    end
  end

  assign rd_data = {ctrl, {PAD_W{1'b0}}};
endmodule

// File: rtl/ds_wake_det.sv
module ds_wake_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_pin,
  output logic wake_lvl,
  output logic wake_rise
);
  logic [SYNC_STAGES-1:0] sreg;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) sreg[0] <= 1'b0;
    else     sreg[0] <= wake_pin;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sreg[i] <= 1'b0;
        else     sreg[i] <= sreg[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sreg[SYNC_STAGES-1];
  end

  assign wake_lvl  = sreg[SYNC_STAGES-1];
  assign wake_rise = sreg[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/ds_warm_timer.sv
module ds_warm_timer
  import deepstop_pkg::*;
#(
  parameter int HI_SHIFT = 0,
  parameter int LO_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       active,
  input  logic       slow_sel,
  input  logic [1:0] wsel,
  input  logic       hi_tick,
  input  logic       lo_tick,
  output logic       done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [31:0]      lim32;
  logic             tick;

  assign lim32 = warm_limit(slow_sel, wsel, HI_SHIFT, LO_SHIFT);
  assign lim   = lim32[CNT_W-1:0];
  assign tick  = slow_sel ? lo_tick : hi_tick;

  always_ff @(posedge clk) begin
    if (rst || load)           cnt_q <= '0;
    else if (active && tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign done = active && tick && (cnt_q == lim - 1'b1);
endmodule

// File: rtl/ds_pad_policy.sv
module ds_pad_policy #(
  parameter int INT_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halted_nxt,
  input  logic             hold_out,
  input  logic [INT_W-1:0] int_pin,
  output logic             pad_hold,
  output logic             pad_hiz,
  output logic             wake_pad_hiz,
  output logic [INT_W-1:0] int_gated,
  output logic [INT_W-1:0] int_fall
);
  logic             force0;
  logic [INT_W-1:0] int_d;

  assign force0 = halted_nxt & ~hold_out;
  assign int_d  = force0 ? '0 : int_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_hold     <= 1'b0;
      pad_hiz      <= 1'b0;
      wake_pad_hiz <= 1'b0;
      int_gated    <= '0;
      int_fall     <= '0;
    end else begin
      pad_hold     <= halted_nxt & hold_out;
      pad_hiz      <= halted_nxt & ~hold_out;
      wake_pad_hiz <= halted_nxt;
      int_gated    <= int_d;
      int_fall     <= int_gated & ~int_d;
    end
  end
endmodule

// File: rtl/deepstop_seq.sv
module deepstop_seq
  import deepstop_pkg::*;
#(
  parameter int HI_SHIFT    = 0,
  parameter int LO_SHIFT    = 0,
  parameter int SYNC_STAGES = 2,
  parameter int INT_W       = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             wake_pin,
  input  logic             pin_reset,
  input  logic             hi_tick,
  input  logic             lo_tick,
  input  logic [INT_W-1:0] int_pin,
  output logic [1:0]       mode_o,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             pad_hold,
  output logic             pad_hiz,
  output logic             wake_pad_hiz,
  output logic [INT_W-1:0] int_gated,
  output logic [INT_W-1:0] int_fall
);
  ds_state_e state_q, state_d;
  ds_ctrl_t  ctrl;
  logic      tgt_slow_q, tgt_slow_d;
  logic      run_slow_q, run_slow_d;
  logic      clr_start, load_cnt, warm_done;
  logic      wake_lvl, wake_rise;
  logic      halted_nxt;

  ds_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_allow(state_q == ST_RUN), .clr_start(clr_start),
    .ctrl(ctrl), .rd_data(rd_data)
  );

  ds_wake_det #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk(clk), .rst(rst), .wake_pin(wake_pin),
    .wake_lvl(wake_lvl), .wake_rise(wake_rise)
  );

  ds_warm_timer #(.HI_SHIFT(HI_SHIFT), .LO_SHIFT(LO_SHIFT)) u_timer (
    .clk(clk), .rst(rst), .load(load_cnt), .active(state_q == ST_WARM),
    .slow_sel(tgt_slow_q), .wsel(ctrl.wsel),
    .hi_tick(hi_tick), .lo_tick(lo_tick), .done(warm_done)
  );

  always_comb begin
    state_d    = state_q;
    tgt_slow_d = tgt_slow_q;
    run_slow_d = run_slow_q;
    clr_start  = 1'b0;
    load_cnt   = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (ctrl.start) begin
          if (ctrl.lvl_rel && wake_lvl) clr_start = 1'b1;
          else                          state_d   = ST_STOP;
        end
      end
      ST_STOP: begin
        if (pin_reset) begin
          state_d    = ST_WARM;
          load_cnt   = 1'b1;
          tgt_slow_d = 1'b0;
        end else if (ctrl.lvl_rel ? wake_lvl : wake_rise) begin
          state_d    = ST_WARM;
          load_cnt   = 1'b1;
          tgt_slow_d = ctrl.ret_slow;
        end
      end
      ST_WARM: begin
        if (warm_done) begin
          state_d    = ST_RUN;
          clr_start  = 1'b1;
          run_slow_d = tgt_slow_q;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign halted_nxt = (state_d != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_RUN;
      tgt_slow_q    <= 1'b0;
      run_slow_q    <= 1'b0;
      mode_o        <= MODE_FAST;
      core_clk_en   <= 1'b1;
      periph_clk_en <= 1'b1;
    end else begin
      state_q       <= state_d;
      tgt_slow_q    <= tgt_slow_d;
      run_slow_q    <= run_slow_d;
      core_clk_en   <= ~halted_nxt;
      periph_clk_en <= ~halted_nxt;
      case (state_d)
        ST_STOP: mode_o <= MODE_STOP;
        ST_WARM: mode_o <= MODE_WARM;
        default: mode_o <= run_slow_d ? MODE_SLOW : MODE_FAST;
      endcase
    end
  end

  ds_pad_policy #(.INT_W(INT_W)) u_pad (
    .clk(clk), .rst(rst), .halted_nxt(halted_nxt), .hold_out(ctrl.hold_out),
    .int_pin(int_pin), .pad_hold(pad_hold), .pad_hiz(pad_hiz),
    .wake_pad_hiz(wake_pad_hiz), .int_gated(int_gated), .int_fall(int_fall)
  );
endmodule

// File: rtl/deepstop_chk.sv
module deepstop_chk #(
  parameter int INT_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             pin_reset,
  input logic [1:0]       mode_o,
  input logic             core_clk_en,
  input logic             periph_clk_en,
  input logic             pad_hold,
  input logic             pad_hiz,
  input logic             wake_pad_hiz,
  input logic [INT_W-1:0] int_gated,
  input logic [INT_W-1:0] int_fall,
  input logic [7:0]       rd_data
);
  logic pr_flag;

  always_ff @(posedge clk) begin
    if (rst) pr_flag <= 1'b0;
    else if (mode_o == 2'b10 && pin_reset) pr_flag <= 1'b1;
    else if (!mode_o[1]) pr_flag <= 1'b0;
  end

  assert_enables_track_R3: assert property (@(posedge clk) disable iff (rst)
    (core_clk_en == periph_clk_en) && (core_clk_en == !mode_o[1]));

  assert_wake_pad_hiz_R10: assert property (@(posedge clk) disable iff (rst)
    mode_o[1] |-> wake_pad_hiz);

  assert_pads_free_in_run_R10: assert property (@(posedge clk) disable iff (rst)
    !mode_o[1] |-> (!pad_hold && !pad_hiz && !wake_pad_hiz));

  assert_policy_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(pad_hold && pad_hiz));

  assert_stop_goes_warm_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b10) |=> mode_o[1]);

  assert_pinreset_release_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b10 && pin_reset) |=> (mode_o == 2'b11));

  assert_pinreset_fast_R8: assert property (@(posedge clk) disable iff (rst)
    pr_flag |-> (mode_o != 2'b01));

  assert_fall_gated_low_R11: assert property (@(posedge clk) disable iff (rst)
    (int_fall & int_gated) == '0);

  assert_unused_bits_R2: assert property (@(posedge clk) disable iff (rst)
    rd_data[1:0] == 2'b00);
endmodule

bind deepstop_seq deepstop_chk #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst(rst), .pin_reset(pin_reset), .mode_o(mode_o),
  .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
  .pad_hold(pad_hold), .pad_hiz(pad_hiz), .wake_pad_hiz(wake_pad_hiz),
  .int_gated(int_gated), .int_fall(int_fall), .rd_data(rd_data)
);

// File: tb/deepstop_seq_tb.sv
module deepstop_seq_tb;
  localparam int HS = 10;
  localparam int LS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wake_pin = 1'b0;
  logic       pin_reset = 1'b0;
  logic       hi_tick = 1'b0;
  logic       lo_tick = 1'b0;
  logic [0:0] int_pin = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] mode_o;
  logic       core_clk_en, periph_clk_en, pad_hold, pad_hiz, wake_pad_hiz;
  logic [0:0] int_gated, int_fall;

  always #10 clk = ~clk;

  deepstop_seq #(.HI_SHIFT(HS), .LO_SHIFT(LS), .SYNC_STAGES(2), .INT_W(1)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wake_pin(wake_pin), .pin_reset(pin_reset), .hi_tick(hi_tick), .lo_tick(lo_tick),
    .int_pin(int_pin), .mode_o(mode_o), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .pad_hold(pad_hold), .pad_hiz(pad_hiz),
    .wake_pad_hiz(wake_pad_hiz), .int_gated(int_gated), .int_fall(int_fall)
  );

  int errors = 0;
  int checks = 0;
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: 0 run, 1 stopped, 2 warm-up
  int       m_st = 0;
  bit       m_slow = 0, m_tgt = 0;
  bit [5:0] m_ctrl = 0;
  bit       m_s0 = 0, m_s1 = 0, m_prev = 0;
  int       m_cnt = 0;
  bit       m_gated = 0, m_fall = 0, m_phold = 0, m_phiz = 0;

  function automatic int lim_f(bit slow, bit [1:0] sel);
    int v;
    if (!slow) v = (sel == 0) ? (3 << 16) : (sel == 1) ? (1 << 16) : (sel == 2) ? (3 << 14) : (1 << 14);
    else       v = (sel == 0) ? (3 << 13) : (sel == 1) ? (1 << 13) : (sel == 2) ? (3 << 6) : (1 << 6);
    v = v >> (slow ? LS : HS);
    return (v < 1) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_slow = 0; m_tgt = 0; m_ctrl = 0; m_s0 = 0; m_s1 = 0; m_prev = 0;
      m_cnt = 0; m_gated = 0; m_fall = 0; m_phold = 0; m_phiz = 0;
    end else begin
      int  nst;
      bit  clr, ld, tick, dn, frc, d;
      nst = m_st; clr = 0; ld = 0;
      tick = m_tgt ? lo_tick : hi_tick;
      dn = (m_st == 2) && tick && (m_cnt == lim_f(m_tgt, m_ctrl[1:0]) - 1);
      if (m_st == 0) begin
        if (m_ctrl[5]) begin
          if (m_ctrl[4] && m_s1) clr = 1; else nst = 1;
        end
      end else if (m_st == 1) begin
        if (pin_reset) begin nst = 2; ld = 1; m_tgt = 0; end
        else if (m_ctrl[4] ? m_s1 : (m_s1 && !m_prev)) begin nst = 2; ld = 1; m_tgt = m_ctrl[3]; end
      end else if (dn) begin
        nst = 0; clr = 1; m_slow = m_tgt;
      end
      frc = (nst != 0) && !m_ctrl[2];
      d = frc ? 1'b0 : int_pin[0];
      m_fall = m_gated && !d;
      m_gated = d;
      m_phold = (nst != 0) && m_ctrl[2];
      m_phiz = (nst != 0) && !m_ctrl[2];
      if (ld) m_cnt = 0; else if (m_st == 2 && tick) m_cnt++;
      if (wr_en && m_st == 0) m_ctrl = wr_data[7:2];
      else if (clr) m_ctrl[5] = 0;
      m_prev = m_s1; m_s1 = m_s0; m_s0 = wake_pin;
      m_st = nst;
    end
  end

  function automatic int m_mode();
    return (m_st == 1) ? 2 : (m_st == 2) ? 3 : (m_slow ? 1 : 0);
  endfunction

  // Per-clock comparison against the model
  initial forever begin
    @(negedge clk);
    if (!rst && !done_flag) begin
      chk(mode_o == m_mode(), "R3/R5/R9 mode", mode_o, m_mode());
      chk(core_clk_en == (m_st == 0) && periph_clk_en == (m_st == 0), "R3 clock enables",
          {core_clk_en, periph_clk_en}, (m_st == 0) ? 3 : 0);
      chk(rd_data == {m_ctrl, 2'b00}, "R2 readback", rd_data, {m_ctrl, 2'b00});
      chk(pad_hold == m_phold && pad_hiz == m_phiz, "R10 pad policy",
          {pad_hold, pad_hiz}, {m_phold, m_phiz});
      chk(wake_pad_hiz == (m_st != 0), "R10 wake pad", wake_pad_hiz, m_st != 0);
      chk(int_gated[0] == m_gated && int_fall[0] == m_fall, "R11 gated input/fall",
          {int_gated[0], int_fall[0]}, {m_gated, m_fall});
    end
  end

  // Oscillator tick strobes
  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c++;
      hi_tick = (c % 2 == 0);
      lo_tick = (c % 8 == 0);
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_release(output int wc);
    wc = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (mode_o == 2'b11) wc++;
      else if (wc > 0) break;
    end
  endtask

  initial begin
    int wc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 8'h00, "R1 reset byte", rd_data, 0);
    chk(mode_o == 2'b00, "R1 reset mode", mode_o, 0);
    chk(core_clk_en && periph_clk_en, "R1 reset enables", core_clk_en, 1);
    chk(!pad_hold && !pad_hiz && !wake_pad_hiz && !int_fall[0], "R1 reset pads", pad_hiz, 0);

    // Edge release, high-speed return, high-Z policy, code 11
    int_pin = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h8C);
    @(negedge clk);
    chk(mode_o == 2'b10, "R3 stop entry", mode_o, 2);
    chk(pad_hiz && !pad_hold && wake_pad_hiz, "R10 high-Z policy", pad_hiz, 1);
    chk(int_gated[0] == 1'b0, "R11 input forced low", int_gated[0], 0);
    wake_pin = 1'b1;
    wait_release(wc);
    chk(wc >= 31 && wc <= 32, "R6 fast warm-up length", wc, 32);
    chk(mode_o == 2'b00, "R9 fast return", mode_o, 0);
    chk(rd_data[7] == 1'b0, "R9 request cleared", rd_data[7], 0);
    wake_pin = 1'b0;
    repeat (4) @(negedge clk);

    // Level release, low-speed return, hold policy, code 10
    wr(8'hF8);
    @(negedge clk);
    chk(pad_hold && !pad_hiz, "R10 hold policy", pad_hold, 1);
    chk(int_gated[0] == 1'b1, "R11 input passes under hold", int_gated[0], 1);
    wr(8'h00);
    chk(rd_data == 8'hF8, "R2 write ignored while stopped", rd_data, 8'hF8);
    repeat (5) @(negedge clk);
    chk(mode_o == 2'b10, "R5 level mode waits", mode_o, 2);
    wake_pin = 1'b1;
    wait_release(wc);
    chk(wc >= 89 && wc <= 96, "R7 slow warm-up length", wc, 96);
    chk(mode_o == 2'b01, "R9 slow return", mode_o, 1);

    // Level request with pin already active: no entry
    wr(8'hC0);
    repeat (3) @(negedge clk);
    chk(mode_o == 2'b01, "R4 no stop entry", mode_o, 1);
    chk(rd_data[7] == 1'b0, "R4 request cleared", rd_data[7], 0);

    // Edge mode with pin already high: must wait for a new rising edge
    wr(8'h8C);
    repeat (10) @(negedge clk);
    chk(mode_o == 2'b10, "R5 held level ignored in edge mode", mode_o, 2);
    wake_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk(mode_o == 2'b10, "R5 falling edge ignored", mode_o, 2);
    wake_pin = 1'b1;
    wait_release(wc);
    chk(mode_o == 2'b00, "R5 rising edge releases", mode_o, 0);
    wake_pin = 1'b0;
    repeat (4) @(negedge clk);

    // Reset-pin release overrides slow return; code 01
    pin_reset = 1'b1;
    repeat (2) @(negedge clk);
    pin_reset = 1'b0;
    chk(mode_o == 2'b00, "R8 pin reset ignored while running", mode_o, 0);
    wr(8'hA4);
    repeat (3) @(negedge clk);
    pin_reset = 1'b1;
    @(negedge clk);
    pin_reset = 1'b0;
    wait_release(wc);
    chk(wc >= 126 && wc <= 128, "R8 fast-table length", wc + 1, 128);
    chk(mode_o == 2'b00, "R8 fast return forced", mode_o, 0);

    // Overlap sweep: wakeup rise against level-mode request
    for (int off = 0; off < 6; off++) begin
      wake_pin = 1'b0;
      repeat (5) @(negedge clk);
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        if (j == off) wake_pin = 1'b1;
        if (j == 3) begin wr_en = 1'b1; wr_data = 8'hCC; end
        else wr_en = 1'b0;
      end
      repeat (60) @(negedge clk);
      chk(mode_o == 2'b00, "R4/R9 overlap final mode", mode_o, 0);
      chk(rd_data[7] == 1'b0, "R4/R9 overlap request cleared", rd_data[7], 0);
    end
    wake_pin = 1'b0;
    repeat (5) @(negedge clk);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule